// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block sits in a receive path and decides whether a frame whose destination address is multicast should be kept. The six destination-address bytes arrive one per cycle on a byte stream. The first byte is marked by a start strobe. As the bytes arrive, the block folds them into a CRC-32. After the last byte, the top bits of the CRC form an index into a 64-bit hash table. The table bit at that index decides the frame.

The table is held in two 32-bit registers that the host writes through a select and write strobe. Matching applies only while the hash-enable configuration input is high. The all-ones broadcast address always passes, without using the table. A unicast address is never accepted by this block, because exact unicast matching is done elsewhere. The host computes the same CRC in software for each group address it wants to receive, and sets the matching table bit.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset both table registers are zero and `dec_valid` is low. A multicast frame sent with hashing enabled and no table write is rejected.
- R2: The CRC starts at 0xFFFFFFFF and shifts left. When the shifted-out bit XOR the data bit is 1, it is XORed with 0x04C11DB7. Bytes are used in stream order, and each byte enters bit 0 first. There is no final inversion. `dec_index` equals CRC bits 31..26.
- R3: Table bit k (k = 0..63) is bit k of the low register (`hash_sel` = 0) for k < 32, and bit k-32 of the high register (`hash_sel` = 1) otherwise. Equivalently, index bits 5..3 pick a byte and bits 2..0 pick the bit within it.
- R4: A multicast frame that is not broadcast is accepted exactly when `cfg_hash_en` is 1 and the table bit at its index is 1. A frame is multicast when bit 0 of its first byte is 1.
- R5: While `cfg_hash_en` is 0, every non-broadcast multicast frame is rejected, whatever the table holds.
- R6: A frame whose first byte has bit 0 equal to 0 is rejected.
- R7: The address FF:FF:FF:FF:FF:FF is accepted regardless of `cfg_hash_en` and the table.
- R8: `dec_valid` is a single-cycle pulse in the cycle after the sixth byte is taken. `dec_accept` and `dec_index` are meaningful while it is high.
- R9: Cycles with `addr_valid` low between bytes pause the frame and do not change the result.
- R10: A byte with `addr_start` high restarts the frame and discards earlier partial bytes. Bytes after the sixth that arrive without `addr_start` are ignored and produce no further decision.
- R11: A table write with `hash_wr` high updates the selected register at that clock edge and leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hash_en | input | 1 | Enable multicast hash matching |
| hash_wr | input | 1 | Table register write strobe |
| hash_sel | input | 1 | Register select: 0 low half, 1 high half |
| hash_wdata | input | 32 | Table register write data |
| addr_valid | input | 1 | Address byte valid |
| addr_start | input | 1 | Marks the first address byte |
| addr_byte | input | 8 | Address byte, first destination byte first |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_index | output | 6 | Hash index of the frame |

## Verification
The hardest case to reach from the ports is showing that exactly one table bit, and no neighbour, decides a frame. The index depends on a full CRC and cannot be chosen directly. The bench therefore computes the index of a chosen multicast address with its own CRC model. It loads a table holding only that bit and expects acceptance. It then loads the complement of that table and expects rejection. The same address is also sent with idle gaps, and after an aborted partial frame, to show that the CRC state is restarted and paused correctly.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

   // byte enters low bit first
   function automatic logic [31:0] crc_step_lsb(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      logic fb;
      r = c;
      for (int j = 0; j < 8; j++) begin
         fb = r[31] ^ d[j];
         r  = {r[30:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction

   // byte enters high bit first
   function automatic logic [31:0] crc_step_msb(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      logic fb;
      r = c;
      for (int j = 7; j >= 0; j--) begin
         fb = r[31] ^ d[j];
         r  = {r[30:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction
endpackage

// File: rtl/mhf_addr_crc.sv
module mhf_addr_crc
   import mhf_pkg::*;
#(
   parameter int ADDR_BYTES    = 6,
   parameter int IDX_W         = 6,
   parameter bit BIT_LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_valid,
   input  logic             addr_start,
   input  logic [7:0]       addr_byte,
   output logic             done,
   output logic             is_mcast,
   output logic             is_bcast,
   output logic [IDX_W-1:0] index
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

   logic [CNT_W-1:0] cnt_q;
   logic [31:0]      crc_q, crc_base, crc_nxt;
   logic             mc_q, bc_q, done_q;

   generate
      if (ADDR_BYTES < 2) begin : g_bad_len
         $error("ADDR_BYTES must be at least 2");
      end
      if (IDX_W < 1 || IDX_W > 32) begin : g_bad_idx
         $error("IDX_W must be within 1..32");
      end
   endgenerate

   assign crc_base = addr_start ? CRC_SEED : crc_q;

   generate
      if (BIT_LSB_FIRST) begin : g_lsb
         assign crc_nxt = crc_step_lsb(crc_base, addr_byte);
      end else begin : g_msb
         assign crc_nxt = crc_step_msb(crc_base, addr_byte);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         crc_q  <= CRC_SEED;
         mc_q   <= 1'b0;
         bc_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (addr_valid) begin
            if (addr_start) begin
               cnt_q <= CNT_W'(1);
               crc_q <= crc_nxt;
               mc_q  <= addr_byte[0];
               bc_q  <= &addr_byte;
            end else if (cnt_q != '0 && cnt_q != LAST) begin
               cnt_q <= cnt_q + CNT_W'(1);
               crc_q <= crc_nxt;
               bc_q  <= bc_q & (&addr_byte);
               if (cnt_q == LAST - CNT_W'(1)) done_q <= 1'b1;
            end
         end
      end
   end

   assign done     = done_q;
   assign is_mcast = mc_q;
   assign is_bcast = bc_q;
   assign index    = crc_q[31 -: IDX_W];

   // R8: decision strobe lasts one cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R8: decision follows a taken byte
   a_r8_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(addr_valid));
   // R10: byte counter never passes the address length
   a_r10_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
   parameter int REG_W      = 32,
   parameter int TABLE_BITS = 64,
   parameter int IDX_W      = 6,
   parameter int NREGS      = 2,
   parameter int SEL_W      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] sel,
   input  logic [REG_W-1:0] wdata,
   input  logic [IDX_W-1:0] index,
   output logic             hit
);
   logic [REG_W-1:0]      regs_q [NREGS];
   logic [TABLE_BITS-1:0] flat;

   generate
      if (NREGS * REG_W != TABLE_BITS) begin : g_bad_split
         $error("TABLE_BITS must equal NREGS * REG_W");
      end
      for (genvar k = 0; k < NREGS; k++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) regs_q[k] <= '0;
            else if (wr && sel == SEL_W'(k)) regs_q[k] <= wdata;
         end
         assign flat[k*REG_W +: REG_W] = regs_q[k];

         // R11: a write lands in the selected register only
         a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && sel == SEL_W'(k)) |=> regs_q[k] == $past(wdata));
         a_r11_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr || sel != SEL_W'(k)) |=> $stable(regs_q[k]));
      end
   endgenerate

   assign hit = flat[index];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
   parameter int ADDR_BYTES    = 6,
   parameter int REG_W         = 32,
   parameter int TABLE_BITS    = 64,
   parameter bit BIT_LSB_FIRST = 1'b1,
   localparam int IDX_W        = $clog2(TABLE_BITS),
   localparam int NREGS        = TABLE_BITS / REG_W,
   localparam int SEL_W        = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_hash_en,
   input  logic             hash_wr,
   input  logic [SEL_W-1:0] hash_sel,
   input  logic [REG_W-1:0] hash_wdata,
   input  logic             addr_valid,
   input  logic             addr_start,
   input  logic [7:0]       addr_byte,
   output logic             dec_valid,
   output logic             dec_accept,
   output logic [IDX_W-1:0] dec_index
);
   logic             done, mc, bc, hit;
   logic [IDX_W-1:0] idx;

   generate
      if ((1 << IDX_W) != TABLE_BITS) begin : g_bad_table
         $error("TABLE_BITS must be a power of two");
      end
   endgenerate

   mhf_addr_crc #(
      .ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W), .BIT_LSB_FIRST(BIT_LSB_FIRST)
   ) u_crc (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_start(addr_start),
      .addr_byte(addr_byte), .done(done), .is_mcast(mc), .is_bcast(bc), .index(idx)
   );

   mhf_hash_table #(
      .REG_W(REG_W), .TABLE_BITS(TABLE_BITS), .IDX_W(IDX_W), .NREGS(NREGS), .SEL_W(SEL_W)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr(hash_wr), .sel(hash_sel), .wdata(hash_wdata),
      .index(idx), .hit(hit)
   );

   assign dec_valid  = done;
   assign dec_index  = idx;
   assign dec_accept = done & (bc | (mc & cfg_hash_en & hit));

   // R7: broadcast passes whatever the configuration
   a_r7_bcast_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && bc) |-> dec_accept);
   // R6: unicast never passes
   a_r6_ucast_block: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !mc) |-> !dec_accept);
endmodule

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   // {address, low register, high register, hash enable}
   localparam logic [112:0] VEC [NVEC] = '{
      {48'h01005E000001, 32'hFFFFFFFF, 32'h00000000, 1'b1},
      {48'h01005E000001, 32'h00000000, 32'hFFFFFFFF, 1'b1},
      {48'h333300000001, 32'hAAAAAAAA, 32'h55555555, 1'b1},
      {48'h0180C2000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0},
      {48'h001122334455, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
      {48'hFFFFFFFFFFFF, 32'h00000000, 32'h00000000, 1'b0},
      {48'h0300000000AB, 32'h12345678, 32'h9ABCDEF0, 1'b1},
      {48'hFFFFFFFFFFFE, 32'h0F0F0F0F, 32'hF0F0F0F0, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_hash_en = 1'b0, hash_wr = 1'b0, addr_valid = 1'b0, addr_start = 1'b0;
   logic [0:0]  hash_sel = '0;
   logic [31:0] hash_wdata = '0;
   logic [7:0]  addr_byte = '0;
   logic        dec_valid, dec_accept;
   logic [5:0]  dec_index;
   int checks = 0, fails = 0;
   logic [31:0] tlo = '0, thi = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcast_hash_filter uut (
      .clk(clk), .rst_n(rst_n), .cfg_hash_en(cfg_hash_en), .hash_wr(hash_wr),
      .hash_sel(hash_sel), .hash_wdata(hash_wdata), .addr_valid(addr_valid),
      .addr_start(addr_start), .addr_byte(addr_byte), .dec_valid(dec_valid),
      .dec_accept(dec_accept), .dec_index(dec_index)
   );

   function automatic logic [5:0] ref_index(input logic [47:0] a);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int k = 0; k < 6; k++) begin
         for (int j = 0; j < 8; j++) begin
            logic fb;
            fb = c[31] ^ a[47 - 8*k - 7 + j];
            c  = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
         end
      end
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [47:0] a, input logic [31:0] lo,
                                       input logic [31:0] hi, input logic en);
      logic [63:0] t = {hi, lo};
      if (a == 48'hFFFFFFFFFFFF) return 1'b1;
      if (!a[40]) return 1'b0;
      return en & t[ref_index(a)];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [31:0] d);
      @(negedge clk);
      hash_wr = 1'b1; hash_sel = sel; hash_wdata = d;
      @(negedge clk);
      hash_wr = 1'b0;
      if (sel) thi = d; else tlo = d;
   endtask

   task automatic send(input logic [47:0] a, input bit gaps);
      for (int k = 0; k < 6; k++) begin
         if (gaps && k > 0) begin
            @(negedge clk);
            addr_valid = 1'b0;
         end
         @(negedge clk);
         addr_valid = 1'b1; addr_start = (k == 0); addr_byte = a[47 - 8*k -: 8];
      end
      @(negedge clk);
      addr_valid = 1'b0; addr_start = 1'b0;
   endtask

   // sample after send: decision, then no second pulse
   task automatic expect_frame(input string req, input logic [47:0] a);
      chk({req, " valid"}, dec_valid, 1);
      chk({req, " accept"}, dec_accept, ref_accept(a, tlo, thi, cfg_hash_en));
      chk({req, " index"}, dec_index, ref_index(a));
      @(negedge clk);
      chk({req, " R8 single pulse"}, dec_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [47:0] a;
      logic [5:0]  ix;
      logic [63:0] t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 no decision after reset", dec_valid, 0);
      cfg_hash_en = 1'b1;
      send(48'h01005E000001, 1'b0);
      chk("R1 cleared table rejects", dec_accept, 0);
      chk("R1 decision present", dec_valid, 1);
      @(negedge clk);

      // R2 R3 R4 R5 R6 R7: vector walk
      for (int v = 0; v < NVEC; v++) begin
         wr_reg(1'b0, VEC[v][64:33]);
         wr_reg(1'b1, VEC[v][32:1]);
         cfg_hash_en = VEC[v][0];
         send(VEC[v][112:65], 1'b0);
         expect_frame("R2/R4/R5/R6/R7 vector", VEC[v][112:65]);
      end

      // R3: only the indexed bit accepts; every other bit rejects
      a  = 48'h01005E7F1234;
      ix = ref_index(a);
      t  = 64'd1 << ix;
      cfg_hash_en = 1'b1;
      wr_reg(1'b0, t[31:0]); wr_reg(1'b1, t[63:32]);
      send(a, 1'b0);
      chk("R3 lone bit accepts", dec_accept, 1);
      chk("R2 index", dec_index, ix);
      t = ~t;
      wr_reg(1'b0, t[31:0]); wr_reg(1'b1, t[63:32]);
      send(a, 1'b0);
      chk("R3 complement rejects", dec_accept, 0);

      // R5: enable off with lone bit set
      t = ~t;
      wr_reg(1'b0, t[31:0]); wr_reg(1'b1, t[63:32]);
      cfg_hash_en = 1'b0;
      send(a, 1'b0);
      chk("R5 disabled rejects", dec_accept, 0);
      cfg_hash_en = 1'b1;

      // R9: idle gaps between bytes
      send(a, 1'b1);
      expect_frame("R9 gapped", a);

      // R10: aborted partial frame then restart
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         addr_valid = 1'b1; addr_start = (k == 0); addr_byte = 8'h5A + 8'(k);
      end
      send(a, 1'b0);
      expect_frame("R10 restart", a);
      // R10: trailing bytes without start are ignored
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         addr_valid = 1'b1; addr_start = 1'b0; addr_byte = 8'hC3;
         @(negedge clk);
         addr_valid = 1'b0;
         chk("R10 trailing byte no decision", dec_valid, 0);
      end

      // R11: writing the other register leaves the hit intact
      if (ix[5]) wr_reg(1'b0, 32'h0); else wr_reg(1'b1, 32'h0);
      send(a, 1'b0);
      chk("R11 other register untouched", dec_accept, 1);
      if (ix[5]) wr_reg(1'b1, 32'h0); else wr_reg(1'b0, 32'h0);
      send(a, 1'b0);
      chk("R11 cleared register rejects", dec_accept, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule